// File: doc/BRIEF.md
# Group-Ordered Atomic Sequencer

The sequencer runs one atomic add per thread group on a single shared counter, and it runs them in group-id order. That makes it suitable as the carry-propagation step of a global prefix sum. A requester presents a group id, an addend and a return tag. When the group is the one next in line, the block returns the counter value from before the add and writes the sum back in the same cycle. It then moves on to the next expected group.

A group that arrives before its turn is parked in a small pending table. No retry is needed from the requester, so the requesting wave can sleep while other waves on its unit keep issuing. Each group must issue the operation exactly once, starting from group 0 after reset.

A request whose id has already been passed is illegal. Such a request is flagged and discarded. When the table is full, the block pushes back on new requests. The one exception is the group currently expected, which is always accepted so that the order can never lock up.

Top module: `ordered_atomic_seq`

## Requirements
- R1: After reset, `rsp_valid` and `err_stale` are 0 and `req_ready` is 1. The counter holds 0 and the expected group is 0.
- R2: Grants occur strictly in ascending group order starting at 0, one per group. Each grant returns in `rsp_old` the sum of the addends of all lower-numbered groups.
- R3: A request accepted at a clock edge whose group id equals the expected group, with no parked entry for that group, is answered with `rsp_valid`=1 during the cycle after that edge.
- R4: A request whose id is above the expected group is parked. It is granted at the edge after the edge where the expected group reaches its id, so a parked run of consecutive ids drains at one grant per cycle.
- R5: `rsp_tag` on every grant equals the tag presented with that group's request.
- R6: With all PEND entries occupied, `req_ready` is 0 for any request whose id differs from the expected group, and such a request is not stored. It is 1 for a request carrying the expected id, and that request is granted as in R3.
- R7: A request whose id is below the expected group sets `err_stale` to 1 for exactly the cycle after its accepting edge. It produces no response and leaves the counter and the expected group unchanged.
- R8: The counter is DATA_W bits wide and wraps modulo 2^DATA_W. The value returned after a wrap is the truncated sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a new launch |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when high together with `req_valid` |
| req_gid | input | GID_W | Group id of the requester |
| req_addend | input | DATA_W | Value to add to the shared counter |
| req_tag | input | TAG_W | Tag echoed on the response |
| rsp_valid | output | 1 | One-cycle grant response |
| rsp_old | output | DATA_W | Counter value before this group's add |
| rsp_tag | output | TAG_W | Tag of the granted request |
| err_stale | output | 1 | One-cycle flag for a request whose group has already been passed |

## Verification
A request for the expected group is answered one clock edge after it is accepted. A parked group is answered one edge after its predecessor's grant edge, so a parked run shows up on consecutive cycles. The stale-id flag also rises one edge after acceptance and lasts a single cycle. The bench drives every request on a falling edge and samples at the following falling edges. Each expected response is therefore checked in the exact cycle it is due, and the cycles around it are checked to be empty. Expected counter values come from a running sum in the bench, updated in grant order.

// File: rtl/oas_pkg.sv
package oas_pkg;

    localparam int OAS_GID_W_DEF  = 8;
    localparam int OAS_DATA_W_DEF = 16;
    localparam int OAS_TAG_W_DEF  = 4;
    localparam int OAS_PEND_DEF   = 4;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_TABLE  = 2'd1,
        SRC_BYPASS = 2'd2
    } grant_src_e;

    function automatic int oas_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/oas_pend_table.sv
module oas_pend_table
    import oas_pkg::*;
#(
    parameter int PEND   = OAS_PEND_DEF,
    parameter int GID_W  = OAS_GID_W_DEF,
    parameter int DATA_W = OAS_DATA_W_DEF,
    parameter int TAG_W  = OAS_TAG_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [GID_W-1:0]  wr_gid,
    input  logic [DATA_W-1:0] wr_add,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [GID_W-1:0]  exp_gid,
    input  logic              take,
    output logic              full,
    output logic              hit,
    output logic [DATA_W-1:0] hit_add,
    output logic [TAG_W-1:0]  hit_tag
);

    localparam int IDX_W = oas_idx_w(PEND);

    typedef struct packed {
        logic              vld;
        logic [GID_W-1:0]  gid;
        logic [DATA_W-1:0] add;
        logic [TAG_W-1:0]  tag;
    } slot_t;

    slot_t            slots [PEND];
    logic [PEND-1:0]  match;
    logic [PEND-1:0]  freev;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] free_idx;

    for (genvar g = 0; g < PEND; g++) begin : g_slot
        assign match[g] = slots[g].vld && (slots[g].gid == exp_gid);
        assign freev[g] = !slots[g].vld;
    end

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int i = PEND - 1; i >= 0; i--) begin
            if (match[i]) hit_idx  = IDX_W'(i);
            if (freev[i]) free_idx = IDX_W'(i);
        end
    end

    assign hit     = |match;
    assign full    = ~|freev;
    assign hit_add = slots[hit_idx].add;
    assign hit_tag = slots[hit_idx].tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PEND; i++) slots[i] <= '0;
        end else begin
            if (take)  slots[hit_idx].vld <= 1'b0;
            if (wr_en) slots[free_idx]    <= '{vld: 1'b1, gid: wr_gid, add: wr_add, tag: wr_tag};
        end
    end

    // R6: a write never lands in a table that is already full
    p_no_write_full_r6: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);

    // R4: at most one parked entry ever matches the expected group
    p_unique_hit_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

endmodule

// File: rtl/oas_grant_unit.sv
module oas_grant_unit
    import oas_pkg::*;
#(
    parameter int GID_W  = OAS_GID_W_DEF,
    parameter int DATA_W = OAS_DATA_W_DEF,
    parameter int TAG_W  = OAS_TAG_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [GID_W-1:0]  in_gid,
    input  logic [DATA_W-1:0] in_add,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic              tbl_hit,
    input  logic [DATA_W-1:0] tbl_add,
    input  logic [TAG_W-1:0]  tbl_tag,
    output logic [GID_W-1:0]  exp_gid,
    output logic              tbl_take,
    output logic              store_en,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_old,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              err_stale
);

    logic [GID_W-1:0]  exp_q;
    logic [DATA_W-1:0] acc_q;
    logic              in_cur;
    logic              in_late;
    grant_src_e        src;
    logic [DATA_W-1:0] g_add;
    logic [TAG_W-1:0]  g_tag;

    assign in_cur   = in_valid && (in_gid == exp_q);
    assign in_late  = in_valid && (in_gid <  exp_q);
    assign store_en = in_valid && (in_gid >  exp_q);

    always_comb begin
        if (tbl_hit)     src = SRC_TABLE;
        else if (in_cur) src = SRC_BYPASS;
        else             src = SRC_NONE;
    end

    assign tbl_take = (src == SRC_TABLE);
    assign g_add    = (src == SRC_TABLE) ? tbl_add : in_add;
    assign g_tag    = (src == SRC_TABLE) ? tbl_tag : in_tag;
    assign exp_gid  = exp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q     <= '0;
            acc_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_old   <= '0;
            rsp_tag   <= '0;
            err_stale <= 1'b0;
        end else begin
            err_stale <= in_late || (in_cur && tbl_hit);
            if (src != SRC_NONE) begin
                rsp_valid <= 1'b1;
                rsp_old   <= acc_q;
                rsp_tag   <= g_tag;
                acc_q     <= acc_q + g_add;
                exp_q     <= exp_q + 1'b1;
            end else begin
                rsp_valid <= 1'b0;
            end
        end
    end

    // R2: every response coincides with one step of the expected group
    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> exp_q == $past(exp_q) + 1'b1);

    // R7: without a response neither the group pointer nor the counter moves
    p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (exp_q == $past(exp_q)) && (acc_q == $past(acc_q)));

    // R7: the error flag only follows an accepted request
    p_err_cause_r7: assert property (@(posedge clk) disable iff (rst)
        err_stale |-> $past(in_valid));

endmodule

// File: rtl/ordered_atomic_seq.sv
module ordered_atomic_seq
    import oas_pkg::*;
#(
    parameter int PEND   = OAS_PEND_DEF,
    parameter int GID_W  = OAS_GID_W_DEF,
    parameter int DATA_W = OAS_DATA_W_DEF,
    parameter int TAG_W  = OAS_TAG_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [GID_W-1:0]  req_gid,
    input  logic [DATA_W-1:0] req_addend,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_old,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              err_stale
);

    logic              full;
    logic              hit;
    logic [DATA_W-1:0] hit_add;
    logic [TAG_W-1:0]  hit_tag;
    logic [GID_W-1:0]  exp_gid;
    logic              take;
    logic              store_en;
    logic              accept;

    assign req_ready = !full || (req_gid == exp_gid);
    assign accept    = req_valid && req_ready;

    oas_pend_table #(
        .PEND(PEND), .GID_W(GID_W), .DATA_W(DATA_W), .TAG_W(TAG_W)
    ) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (store_en),
        .wr_gid  (req_gid),
        .wr_add  (req_addend),
        .wr_tag  (req_tag),
        .exp_gid (exp_gid),
        .take    (take),
        .full    (full),
        .hit     (hit),
        .hit_add (hit_add),
        .hit_tag (hit_tag)
    );

    oas_grant_unit #(
        .GID_W(GID_W), .DATA_W(DATA_W), .TAG_W(TAG_W)
    ) u_grant (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (accept),
        .in_gid    (req_gid),
        .in_add    (req_addend),
        .in_tag    (req_tag),
        .tbl_hit   (hit),
        .tbl_add   (hit_add),
        .tbl_tag   (hit_tag),
        .exp_gid   (exp_gid),
        .tbl_take  (take),
        .store_en  (store_en),
        .rsp_valid (rsp_valid),
        .rsp_old   (rsp_old),
        .rsp_tag   (rsp_tag),
        .err_stale (err_stale)
    );

    // R6: a request refused at the port never reaches the grant logic
    p_refuse_r6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> !err_stale);

endmodule

// File: tb/ordered_atomic_seq_tb_top.sv
`timescale 1ns/1ps
module ordered_atomic_seq_tb_top;

    localparam int GID_W  = 8;
    localparam int DATA_W = 16;
    localparam int TAG_W  = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [GID_W-1:0]  req_gid = '0;
    logic [DATA_W-1:0] req_addend = '0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_old;
    logic [TAG_W-1:0]  rsp_tag;
    logic              err_stale;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;
    logic [DATA_W-1:0] ref_acc = '0;

    always #2 clk = ~clk;

    ordered_atomic_seq #(.PEND(4), .GID_W(GID_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_gid(req_gid), .req_addend(req_addend), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_old(rsp_old), .rsp_tag(rsp_tag),
        .err_stale(err_stale)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drive at a falling edge, return at the falling edge after the accepting edge
    task automatic issue(input int gid, input int add, input int tag);
        req_valid  = 1'b1;
        req_gid    = GID_W'(gid);
        req_addend = DATA_W'(add);
        req_tag    = TAG_W'(tag);
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    task automatic expect_grant(input string req, input int tag, input int add);
        check(rsp_valid == 1'b1, req, "rsp_valid", rsp_valid, 1);
        check(rsp_old == ref_acc, req, "rsp_old", rsp_old, ref_acc);
        check(rsp_tag == TAG_W'(tag), req, "rsp_tag", rsp_tag, tag);
        ref_acc = ref_acc + DATA_W'(add);
    endtask

    task automatic t_reset_state();
        check(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
        check(err_stale == 1'b0, "R1", "err_stale", err_stale, 0);
        check(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
    endtask

    task automatic t_bypass();
        issue(0, 5, 3);
        expect_grant("R3", 3, 5);
        issue(1, 7, 9);
        expect_grant("R2", 9, 7);
    endtask

    task automatic t_parked_chain();
        issue(4, 3, 4);
        check(rsp_valid == 1'b0, "R4", "parked g4 rsp_valid", rsp_valid, 0);
        issue(3, 2, 5);
        check(rsp_valid == 1'b0, "R4", "parked g3 rsp_valid", rsp_valid, 0);
        issue(2, 1, 6);
        expect_grant("R3", 6, 1);
        @(negedge clk);
        expect_grant("R4", 5, 2);
        @(negedge clk);
        expect_grant("R5", 4, 3);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R4", "drained rsp_valid", rsp_valid, 0);
    endtask

    task automatic t_full_table();
        issue(6, 10, 1);
        issue(7, 20, 2);
        issue(8, 30, 3);
        issue(9, 40, 7);
        req_valid = 1'b1; req_gid = 8'd10; req_addend = 16'd99; req_tag = 4'd8;
        #1;
        check(req_ready == 1'b0, "R6", "req_ready full", req_ready, 0);
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_valid = 1'b1; req_gid = 8'd5; req_addend = 16'd4; req_tag = 4'd11;
        #1;
        check(req_ready == 1'b1, "R6", "req_ready expected id", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        expect_grant("R6", 11, 4);
        @(negedge clk); expect_grant("R4", 1, 10);
        @(negedge clk); expect_grant("R4", 2, 20);
        @(negedge clk); expect_grant("R4", 3, 30);
        @(negedge clk); expect_grant("R4", 7, 40);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R6", "refused g10 not stored", rsp_valid, 0);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R6", "refused g10 not stored", rsp_valid, 0);
        issue(10, 6, 12);
        expect_grant("R2", 12, 6);
    endtask

    task automatic t_stale();
        issue(3, 500, 13);
        check(err_stale == 1'b1, "R7", "err_stale", err_stale, 1);
        check(rsp_valid == 1'b0, "R7", "rsp_valid", rsp_valid, 0);
        @(negedge clk);
        check(err_stale == 1'b0, "R7", "err_stale one cycle", err_stale, 0);
        issue(11, 16'hFFF0, 14);
        expect_grant("R7", 14, 16'hFFF0);
    endtask

    task automatic t_wrap();
        issue(12, 1, 15);
        expect_grant("R8", 15, 1);
        check(rsp_old == 16'd112, "R8", "wrapped value", rsp_old, 112);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_bypass();
        t_parked_chain();
        t_full_table();
        t_stale();
        t_wrap();
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule